// File: doc/BRIEF.md
# ESF Data Link Bit Extractor

This block takes a received ESF T1 bit stream and pulls out the data link bits that ride in the framing-bit slot of odd-numbered frames. An upstream synchronizer supplies a framing-bit strobe and the frame number within the 24-frame multiframe. The block then routes the extracted bits according to two configuration fields.

The bandwidth field picks the full 4 kHz channel or one of the two interleaved 2 kHz channels. The destination field sends the selected bits to a consumer port (for an HDLC decoder or a buffer), or to an overhead output, or to the serial output only. It can also overwrite every data link slot in the serial output with a one.

All outputs are registered. Each result appears one clock after the input cycle that produced it.

Top module: `esf_dl_extract`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is 0 after that edge.
- R2: Outside a forced slot, `rx_ser` equals the `rx_data` value from the previous clock cycle.
- R3: A data link slot is a cycle with `fbit_stb` high and an odd `frame_num` (1, 3, ..., 23). No strobe is raised for any other cycle, including framing bits of even frames.
- R4: With `bw_sel` = 2'b00 or the reserved 2'b11, every data link slot is selected.
- R5: With `bw_sel` = 2'b01, only the slots of frames 1, 5, 9, 13, 17 and 21 are selected.
- R6: With `bw_sel` = 2'b10, only the slots of frames 3, 7, 11, 15, 19 and 23 are selected.
- R7: With `dest_sel` = 2'b00, each selected bit appears on `dl_bit` with `dl_stb` high, and it also stays in `rx_ser`. `oh_stb` stays low.
- R8: With `dest_sel` = 2'b01, both `dl_stb` and `oh_stb` stay low, and the data link bits pass through `rx_ser` only.
- R9: With `dest_sel` = 2'b10, each selected bit appears on `oh_bit` with `oh_stb` high, and it also stays in `rx_ser`. `dl_stb` stays low.
- R10: With `dest_sel` = 2'b11, `rx_ser` is 1 in every data link slot, whatever `bw_sel` is, and no strobe is raised.
- R11: In the 2 kHz modes, unselected data link bits pass to `rx_ser` unchanged unless R10 applies.
- R12: Each strobe is high for exactly one cycle per selected bit. `dl_bit` and `oh_bit` are 0 whenever their strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 1 | Received serial bit |
| fbit_stb | input | 1 | High when the framing bit is on `rx_data` |
| frame_num | input | 5 | Frame number in the multiframe, 1 to 24 |
| bw_sel | input | 2 | Bandwidth code |
| dest_sel | input | 2 | Destination code |
| rx_ser | output | 1 | Serial receive data |
| oh_bit | output | 1 | Overhead output bit |
| oh_stb | output | 1 | Overhead bit valid |
| dl_bit | output | 1 | Consumer data bit |
| dl_stb | output | 1 | Consumer bit valid |

## Verification
Every output is due exactly one clock after the cycle whose inputs produce it. The driver applies the inputs and the configuration on the falling edge and queues the expected result at the same moment. The monitor pops that result shortly after the next rising edge, so each comparison lines up with the one register stage. The run covers every pair of bandwidth and destination codes across whole multiframes.

// File: rtl/esf_dl_extract.sv
module esf_dl_extract #(
  parameter int FRAME_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_data,
  input  logic               fbit_stb,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic [1:0]         bw_sel,
  input  logic [1:0]         dest_sel,
  output logic               rx_ser,
  output logic               oh_bit,
  output logic               oh_stb,
  output logic               dl_bit,
  output logic               dl_stb
);

  localparam logic [1:0] BW_HALF_A = 2'b01;
  localparam logic [1:0] BW_HALF_B = 2'b10;
  localparam logic [1:0] DST_CONS  = 2'b00;
  localparam logic [1:0] DST_OH    = 2'b10;
  localparam logic [1:0] DST_FORCE = 2'b11;

  logic slot, pick, force_one;

  assign slot = fbit_stb & frame_num[0];

  always_comb begin
    case (bw_sel)
      BW_HALF_A: pick = slot & ~frame_num[1];
      BW_HALF_B: pick = slot &  frame_num[1];
      default:   pick = slot;
    endcase
  end

  assign force_one = slot & (dest_sel == DST_FORCE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ser <= 1'b0;
      oh_bit <= 1'b0;
      oh_stb <= 1'b0;
      dl_bit <= 1'b0;
      dl_stb <= 1'b0;
    end else begin
      rx_ser <= rx_data | force_one;
      oh_stb <= pick & (dest_sel == DST_OH);
      oh_bit <= pick & (dest_sel == DST_OH) & rx_data;
      dl_stb <= pick & (dest_sel == DST_CONS);
      dl_bit <= pick & (dest_sel == DST_CONS) & rx_data;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !(rx_ser | oh_bit | oh_stb | dl_bit | dl_stb));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fbit_stb && frame_num[0] && dest_sel == 2'b11) |=> rx_ser == $past(rx_data));

  p_slot_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_stb || dl_stb) |-> ($past(fbit_stb) && $past(frame_num[0])));

  p_cons_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dl_stb |-> ($past(dest_sel) == 2'b00 && dl_bit == $past(rx_data)));

  p_oh_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oh_stb |-> ($past(dest_sel) == 2'b10 && oh_bit == $past(rx_data)));

  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fbit_stb && frame_num[0] && dest_sel == 2'b11) |=> (rx_ser && !oh_stb && !dl_stb));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({oh_stb, dl_stb}) <= 1 && (oh_stb || !oh_bit) && (dl_stb || !dl_bit));

endmodule

// File: tb/esf_dl_extract_bench.sv
module esf_dl_extract_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data = 1'b0;
  logic fbit_stb = 1'b0;
  logic [4:0] frame_num = 5'd1;
  logic [1:0] bw_sel = 2'b00;
  logic [1:0] dest_sel = 2'b00;
  logic rx_ser, oh_bit, oh_stb, dl_bit, dl_stb;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic ser, ohb, ohs, dlb, dls;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  esf_dl_extract u_esf_dl_extract (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .fbit_stb(fbit_stb),
    .frame_num(frame_num), .bw_sel(bw_sel), .dest_sel(dest_sel),
    .rx_ser(rx_ser), .oh_bit(oh_bit), .oh_stb(oh_stb),
    .dl_bit(dl_bit), .dl_stb(dl_stb)
  );

  task automatic report(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic fb, input int fn);
    exp_t e;
    logic dlpos, sel;
    @(negedge clk);
    rx_data = d; fbit_stb = fb; frame_num = 5'(fn);
    dlpos = fb && (fn % 2 == 1);
    if (bw_sel == 2'b01)      sel = dlpos && (fn % 4 == 1);
    else if (bw_sel == 2'b10) sel = dlpos && (fn % 4 == 3);
    else                      sel = dlpos;
    e.ser = (dlpos && dest_sel == 2'b11) ? 1'b1 : d;
    e.dls = sel && dest_sel == 2'b00;
    e.dlb = e.dls ? d : 1'b0;
    e.ohs = sel && dest_sel == 2'b10;
    e.ohb = e.ohs ? d : 1'b0;
    if (dest_sel == 2'b11 && dlpos) e.tag = "R10";
    else if (dlpos && !sel)         e.tag = "R11/R12";
    else if (!dlpos)                e.tag = fb ? "R3/R2" : "R2";
    else if (dest_sel == 2'b00)     e.tag = "R7";
    else if (dest_sel == 2'b01)     e.tag = "R8";
    else                            e.tag = "R9";
    if (sel) e.tag = {e.tag, (bw_sel == 2'b01) ? "/R5" : (bw_sel == 2'b10) ? "/R6" : "/R4"};
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        report(e.tag, "rx_ser", rx_ser, e.ser);
        report(e.tag, "dl_stb", dl_stb, e.dls);
        report(e.tag, "dl_bit", dl_bit, e.dlb);
        report(e.tag, "oh_stb", oh_stb, e.ohs);
        report(e.tag, "oh_bit", oh_bit, e.ohb);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rx_data = 1'b1; fbit_stb = 1'b1; frame_num = 5'd1;
    repeat (3) @(negedge clk);
    report("R1", "rx_ser", rx_ser, 1'b0);
    report("R1", "dl_stb", dl_stb, 1'b0);
    report("R1", "oh_stb", oh_stb, 1'b0);
    report("R1", "dl_bit", dl_bit, 1'b0);
    report("R1", "oh_bit", oh_bit, 1'b0);
    rst_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      for (int d = 0; d < 4; d++) begin
        @(negedge clk);
        bw_sel = 2'(b); dest_sel = 2'(d);
        for (int m = 0; m < 2; m++)
          for (int f = 1; f <= 24; f++)
            for (int p = 0; p < FRAME_BITS; p++)
              drive(1'($urandom_range(0, 1)), p == 0, f);
      end
    end
    for (int f = 1; f <= 24; f++) drive(1'b0, 1'b1, f);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule